// File: doc/BRIEF.md
# DDR Read Data Capture Path

This block takes the read data lines of a double-data-rate memory group and a strobe that has already been delayed into the centre of the data eye. It splits each beat pair into two single-rate words and hands the pair to the core clock domain. A register clocked on the rising strobe edge grabs the first beat. On the falling strobe edge that beat is copied forward and the second beat is taken at the same moment, so the two halves of a pair leave the strobe domain together.

The core side first samples the aligned pair on a core-clock edge whose polarity is chosen by an input. This allows for any phase relation between the strobe and the core clock. A mode input then either presents that result directly (half transfer) or passes it through one more rising-edge core register (full transfer). The core raises a read-enable flag for every core cycle in which a pair is expected. That flag travels through the same stages as the data and comes out as a data-valid flag that is aligned with the output words. Polarity and mode are taken into internal configuration registers only while reset is held or while nothing is in flight.

Top module: `ddr_read_capture`

## Requirements
- R1: The beat sampled on a rising `dqs` edge appears on `outRise`. Within each pair it is the earlier beat, so pair i of a burst shows beat 2i on `outRise`.
- R2: The beat sampled on the following falling `dqs` edge appears on `outFall` in the same output word as its partner, so pair i shows beat 2i+1 on `outFall`.
- R3: In half transfer (`fullXfer`=0) the outputs are driven straight from the core sampling stage. With `clkPolFall`=0 that stage loads on the rising core edge, and with `clkPolFall`=1 on the falling core edge. If a pair is aligned before falling core edge n, and n precedes rising edge n', the pair shows at the output after n (falling polarity) or after n' (rising polarity).
- R4: In full transfer (`fullXfer`=1) the pair shows one rising core edge later than the R3 timing.
- R5: `readEn` is sampled together with the pair at the core sampling edge and moves through the same stages. `dataValid` is therefore high exactly for the output words that carry pairs captured while `readEn` was high, one word per core cycle in burst order.
- R6: Polarity and mode are loaded only on a rising core edge where reset is high, or where `readEn` is low and no valid flag is in flight. A change made during a burst leaves that burst's ordering and latency untouched and takes effect after the burst drains.
- R7: While `ce` is low the core-clock stages hold, so `outRise`, `outFall` and `dataValid` keep their values whatever happens on `dqs`, `dq` and `readEn`.
- R8: Reset is synchronous and active high. While it is held, `dataValid` is 0 and `outRise` and `outFall` are all zeros. The strobe-domain registers clear on strobe edges that occur during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coreClk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Enable for the core-clock stages |
| dqs | input | 1 | Delayed read strobe |
| dq | input | W | Read data lines of the strobe group |
| clkPolFall | input | 1 | Core sampling edge select: 0 rising, 1 falling |
| fullXfer | input | 1 | Transfer mode: 0 half, 1 full (extra stage) |
| readEn | input | 1 | High in each core cycle that expects a beat pair |
| outRise | output | W | Rising-strobe beat of the current pair |
| outFall | output | W | Falling-strobe beat of the current pair |
| dataValid | output | 1 | Output words hold read data |

## Verification
The bench uses the default 8-bit lane. Beat values come from an arithmetic formula of seed and beat index, so a swap of the two halves or a shift by one pair produces a mismatch. All four combinations of polarity and transfer mode are swept, with bursts of one to four pairs. The expected cycle of the first valid word is computed from the selected edge and mode. Further runs flip the polarity in the middle of a burst, hold the enable low during a burst, and reassert reset after traffic.

// File: rtl/ddrcap_pkg.sv
`timescale 1ns/1ps
package ddrcap_pkg;

  // Strobes from the control side to the datapath.
  typedef struct packed {
    logic stage2Load;   // core sampling stage may load
    logic stage3Load;   // extra full-transfer stage may load
    logic selFallEdge;  // take the falling-core-edge sample
    logic selFull;      // present the extra stage on the outputs
  } xferStrobes_t;

endpackage

// File: rtl/ddrcap_datapath.sv
`timescale 1ns/1ps
module ddrcap_datapath
  import ddrcap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         coreClk,
  input  logic         rst,
  input  logic         dqs,
  input  logic [W-1:0] dq,
  input  xferStrobes_t strobes,
  output logic [W-1:0] outRise,
  output logic [W-1:0] outFall
);

  localparam int PAIR_W = 2 * W;

  // Strobe domain: demultiplex and align to the falling strobe edge.
  logic [W-1:0]      riseCap;
  logic [PAIR_W-1:0] alignedPair;   // {rise beat, fall beat}

  always_ff @(posedge dqs) begin
    if (rst) riseCap <= '0;
    else     riseCap <= dq;
  end

  always_ff @(negedge dqs) begin
    if (rst) alignedPair <= '0;
    else     alignedPair <= {riseCap, dq};
  end

  // Core domain, sampling stage: one register per core edge, one used.
  logic [PAIR_W-1:0] sampRise;
  logic [PAIR_W-1:0] sampFall;
  logic [PAIR_W-1:0] stage2Pair;

  always_ff @(posedge coreClk) begin
    if (rst)                     sampRise <= '0;
    else if (strobes.stage2Load) sampRise <= alignedPair;
  end

  always_ff @(negedge coreClk) begin
    if (rst)                     sampFall <= '0;
    else if (strobes.stage2Load) sampFall <= alignedPair;
  end

  assign stage2Pair = strobes.selFallEdge ? sampFall : sampRise;

  // Optional extra rising-edge stage.
  logic [PAIR_W-1:0] stage3Pair;

  always_ff @(posedge coreClk) begin
    if (rst)                     stage3Pair <= '0;
    else if (strobes.stage3Load) stage3Pair <= stage2Pair;
  end

  logic [PAIR_W-1:0] outPair;
  assign outPair = strobes.selFull ? stage3Pair : stage2Pair;
  assign outRise = outPair[PAIR_W-1:W];
  assign outFall = outPair[W-1:0];

endmodule

// File: rtl/ddrcap_control.sv
`timescale 1ns/1ps
module ddrcap_control
  import ddrcap_pkg::*;
(
  input  logic         coreClk,
  input  logic         rst,
  input  logic         ce,
  input  logic         readEn,
  input  logic         clkPolFall,
  input  logic         fullXfer,
  output xferStrobes_t strobes,
  output logic         dataValid,
  output logic         cfgPol,
  output logic         cfgFull
);

  logic validRise;
  logic validFall;
  logic validLate;
  logic validStage2;
  logic pipeIdle;
  logic lateLoad;

  // Configuration may move only when nothing is in flight.
  assign pipeIdle = !readEn && !validRise && !validFall && !validLate;

  always_ff @(posedge coreClk) begin
    if (rst || pipeIdle) begin
      cfgPol  <= clkPolFall;
      cfgFull <= fullXfer;
    end
  end

  // Read-enable flag sampled alongside the data, on both core edges.
  always_ff @(posedge coreClk) begin
    if (rst)     validRise <= 1'b0;
    else if (ce) validRise <= readEn;
  end

  always_ff @(negedge coreClk) begin
    if (rst)     validFall <= 1'b0;
    else if (ce) validFall <= readEn;
  end

  assign validStage2 = cfgPol ? validFall : validRise;
  assign lateLoad    = ce && cfgFull;

  always_ff @(posedge coreClk) begin
    if (rst)           validLate <= 1'b0;
    else if (lateLoad) validLate <= validStage2;
  end

  assign dataValid = cfgFull ? validLate : validStage2;

  always_comb begin
    strobes.stage2Load  = ce;
    strobes.stage3Load  = lateLoad;
    strobes.selFallEdge = cfgPol;
    strobes.selFull     = cfgFull;
  end

endmodule

// File: rtl/ddr_read_capture.sv
`timescale 1ns/1ps
module ddr_read_capture
  import ddrcap_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         coreClk,
  input  logic         rst,
  input  logic         ce,
  input  logic         dqs,
  input  logic [W-1:0] dq,
  input  logic         clkPolFall,
  input  logic         fullXfer,
  input  logic         readEn,
  output logic [W-1:0] outRise,
  output logic [W-1:0] outFall,
  output logic         dataValid
);

  xferStrobes_t strobes;
  logic         cfgPol;
  logic         cfgFull;

  ddrcap_control u_control (
    .coreClk    (coreClk),
    .rst        (rst),
    .ce         (ce),
    .readEn     (readEn),
    .clkPolFall (clkPolFall),
    .fullXfer   (fullXfer),
    .strobes    (strobes),
    .dataValid  (dataValid),
    .cfgPol     (cfgPol),
    .cfgFull    (cfgFull)
  );

  ddrcap_datapath #(.W(W)) u_datapath (
    .coreClk (coreClk),
    .rst     (rst),
    .dqs     (dqs),
    .dq      (dq),
    .strobes (strobes),
    .outRise (outRise),
    .outFall (outFall)
  );

endmodule

// File: rtl/ddrcap_checker.sv
`timescale 1ns/1ps
module ddrcap_checker #(
  parameter int W = 8
) (
  input logic         coreClk,
  input logic         rst,
  input logic         ce,
  input logic         readEn,
  input logic         dataValid,
  input logic [W-1:0] outRise,
  input logic [W-1:0] outFall,
  input logic         cfgPol,
  input logic         cfgFull
);

  // R8: outputs cleared once reset has been seen on two rising edges
  assert_reset_clears_R8: assert property (@(posedge coreClk)
    (rst && $past(rst)) |-> (!dataValid && outRise == '0 && outFall == '0));

  // R6: configuration frozen while a valid word is presented
  assert_cfg_frozen_R6: assert property (@(posedge coreClk) disable iff (rst)
    dataValid |=> ($stable(cfgPol) && $stable(cfgFull)));

  // R5: rising-polarity half mode, valid starts one edge after readEn
  assert_valid_half_R5: assert property (@(posedge coreClk) disable iff (rst)
    (!cfgPol && !cfgFull && $rose(dataValid)) |-> $past(readEn));

  // R5: rising-polarity full mode, valid starts two edges after readEn
  assert_valid_full_R5: assert property (@(posedge coreClk) disable iff (rst)
    (!cfgPol && cfgFull && $rose(dataValid)) |-> $past(readEn, 2));

  // R7: in full mode a low enable holds the outputs
  assert_ce_holds_R7: assert property (@(posedge coreClk) disable iff (rst)
    (cfgFull && !ce) |=>
      (!cfgFull || ($stable(outRise) && $stable(outFall) && $stable(dataValid))));

endmodule

bind ddr_read_capture ddrcap_checker #(.W(W)) u_checker (
  .coreClk   (coreClk),
  .rst       (rst),
  .ce        (ce),
  .readEn    (readEn),
  .dataValid (dataValid),
  .outRise   (outRise),
  .outFall   (outFall),
  .cfgPol    (cfgPol),
  .cfgFull   (cfgFull)
);

// File: tb/ddr_read_capture_tb.sv
`timescale 1ns/1ps
module ddr_read_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          coreClk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b1;
  logic          dqs = 1'b0;
  logic [DW-1:0] dq = '0;
  logic          clkPolFall = 1'b0;
  logic          fullXfer = 1'b0;
  logic          readEn = 1'b0;
  logic [DW-1:0] outRise;
  logic [DW-1:0] outFall;
  logic          dataValid;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 1'b0;

  ddr_read_capture #(.W(DW)) u_dut (
    .coreClk    (coreClk),
    .rst        (rst),
    .ce         (ce),
    .dqs        (dqs),
    .dq         (dq),
    .clkPolFall (clkPolFall),
    .fullXfer   (fullXfer),
    .readEn     (readEn),
    .outRise    (outRise),
    .outFall    (outFall),
    .dataValid  (dataValid)
  );

  // Rising core edges at 5 mod 10, falling at 0 mod 10.
  always #(CLK_PERIOD/2) coreClk = ~coreClk;

  function automatic logic [DW-1:0] beatVal(int seed, int k);
    int v;
    v = seed * 29 + k * 53 + 7;
    return v[DW-1:0];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One burst of pairs, aligned to a falling core edge. Strobe rises at
  // slot+1 and falls at slot+6. Samples are taken at slot+3.
  task automatic runBurst(int pairs, int seed, bit expPol, bit expFull,
                          bit chgPol, bit chgVal, bit expectHold,
                          logic [DW-1:0] holdA, logic [DW-1:0] holdB);
    int off;
    int seen;
    off  = 1 + (expPol ? 0 : 1) + (expFull ? 1 : 0);
    seen = 0;
    @(negedge coreClk);
    fork
      begin
        for (int i = 0; i < pairs; i++) begin
          dq = beatVal(seed, 2*i);
          #1 dqs = 1'b1;
          #3 dq = beatVal(seed, 2*i+1);
          #2 dqs = 1'b0;
          #4;
        end
        dq = '0;
      end
      begin
        #8 readEn = 1'b1;
        #(CLK_PERIOD*pairs) readEn = 1'b0;
      end
      begin
        if (chgPol) begin
          #25 clkPolFall = chgVal;
        end
      end
      begin
        #3;
        for (int k = 0; k < pairs + 5; k++) begin
          if (expectHold) begin
            check(dataValid == 1'b0, "R7", "valid with enable low", int'(dataValid), 0);
            check(outRise == holdA && outFall == holdB, "R7", "held outputs",
                  int'({outRise, outFall}), int'({holdA, holdB}));
          end else begin
            int idx;
            bit inWin;
            idx   = k - off;
            inWin = (idx >= 0) && (idx < pairs);
            check(dataValid == inWin, expFull ? "R4" : "R3", "valid timing",
                  int'(dataValid), int'(inWin));
            if (dataValid && inWin) begin
              seen++;
              check(outRise == beatVal(seed, 2*idx), "R1", "rise beat",
                    int'(outRise), int'(beatVal(seed, 2*idx)));
              check(outFall == beatVal(seed, 2*idx+1), "R2", "fall beat",
                    int'(outFall), int'(beatVal(seed, 2*idx+1)));
            end
          end
          #(CLK_PERIOD);
        end
      end
    join
    if (!expectHold) check(seen == pairs, "R5", "valid word count", seen, pairs);
  endtask

  task automatic settle(bit pol, bit full);
    @(negedge coreClk);
    #3;
    clkPolFall = pol;
    fullXfer   = full;
    repeat (3) @(posedge coreClk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int badMark;
    logic [DW-1:0] lastA;
    logic [DW-1:0] lastB;

    // Strobe edges during reset clear the strobe-domain registers.
    repeat (3) begin
      #2 dqs = 1'b1;
      #2 dqs = 1'b0;
    end
    @(negedge coreClk);
    @(negedge coreClk);
    #3;
    check(dataValid == 1'b0, "R8", "valid in reset", int'(dataValid), 0);
    check(outRise == '0 && outFall == '0, "R8", "outputs in reset",
          int'({outRise, outFall}), 0);
    rst = 1'b0;
    repeat (2) @(posedge coreClk);

    // Sweep: both modes, both polarities, 1 to 4 pairs.
    for (int full = 0; full < 2; full++) begin
      for (int pol = 0; pol < 2; pol++) begin
        for (int n = 1; n <= 4; n++) begin
          settle(pol[0], full[0]);
          runBurst(n, full*8 + pol*4 + n, pol[0], full[0], 1'b0, 1'b0, 1'b0, '0, '0);
        end
      end
    end

    // R6: polarity flipped mid-burst leaves this burst on the old setting.
    settle(1'b0, 1'b0);
    badMark = nBad;
    runBurst(4, 41, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, '0, '0);
    repeat (3) @(posedge coreClk);
    runBurst(3, 42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    check(nBad == badMark, "R6", "config change deferred to idle", nBad - badMark, 0);

    // R7: enable low holds the core stages during a full burst.
    settle(1'b0, 1'b0);
    runBurst(2, 50, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, '0);
    @(negedge coreClk);
    #3;
    lastA = outRise;
    lastB = outFall;
    ce = 1'b0;
    runBurst(3, 51, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, lastA, lastB);
    @(negedge coreClk);
    #3;
    ce = 1'b1;
    settle(1'b1, 1'b1);
    runBurst(2, 52, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);

    // R8: reset after traffic clears the outputs again.
    @(negedge coreClk);
    #3;
    rst = 1'b1;
    #2 dqs = 1'b1;
    #2 dqs = 1'b0;
    repeat (2) @(negedge coreClk);
    #3;
    check(dataValid == 1'b0, "R8", "valid after re-reset", int'(dataValid), 0);
    check(outRise == '0 && outFall == '0, "R8", "outputs after re-reset",
          int'({outRise, outFall}), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule